// File: doc/BRIEF.md
# SPI Read Sample-Point Calibration Sequencer

This block searches for a safe read-sampling point for one SPI clock divider. After a start pulse it asks the flash read engine for one slow, conservative read of a test region. It folds that read into a CRC-32 signature and counts how many words carry real information, meaning words that are neither all zeros nor all ones. If too few words carry information, the region cannot tell good timing from bad, and the block finishes with a "skipped" status.

If the region is usable, the block tries a fixed list of sample-delay candidates in order. It writes each candidate into the divider's field of the timing register, then requests repeated test reads. Each test read's signature is compared with the reference signature. A candidate passes only when every repeat matches. The first mismatch ends that candidate at once.

The sweep stops at the third pass in a row and keeps the middle candidate of that run, which leaves one passing setting of margin on each side. If no such run appears, the divider's field is cleared and the status reports a verify failure. A higher-level controller runs the block once per divider. It walks the dividers from the slowest to the fastest, skips those at or above the frequency limit, and keeps the fastest one that passed.

Top module: `spi_rd_calib`

## Requirements
- R1: After reset, `timing_o` is zero, `status_o` is 0 (none), and `done_o`, `rd_req_o` and `rd_slow_o` are low.
- R2: A start pulse with a valid divider raises `rd_req_o` for one cycle with `rd_slow_o` high, and clears that divider's 4-bit field of `timing_o` (bits 4*(d-1)+3 down to 4*(d-1)) for the reference read.
- R3: A reference word counts as varied when it is neither 0x00000000 nor 0xFFFFFFFF. With fewer than MIN_VARIED varied words, the block finishes with status 2 (skipped), leaves the field at zero and issues no further reads. With exactly MIN_VARIED varied words, the sweep proceeds.
- R4: Candidates are tried in order 0 to CANDS-1. While candidate i is under test, the divider's field holds {~i[0], i[3:1]}: bit 3 (extra input delay) is set for even i, and bits 2:0 give the clock delay i/2. Test reads have `rd_slow_o` low.
- R5: A candidate passes after REPEATS test reads whose CRC-32 matches the reference. A mismatch ends the candidate with no further reads for it.
- R6: On the third consecutive pass, the sweep stops, the field is set to the code of the candidate before the last one, and status becomes 1 (ok). A failing candidate resets the run count to zero.
- R7: If all candidates are tried without three passes in a row, the field is cleared and status becomes 3 (verify failure).
- R8: `done_o` is a one-cycle pulse in the cycle after the last word of the deciding read is accepted. `status_o` changes only with `done_o`, and `timing_o` holds while idle.
- R9: Fields of dividers other than the one under calibration never change.
- R10: A start pulse is ignored while a calibration is running, or when the divider is 0 or above NDIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| div_i | input | $clog2(NDIV+1) | Divider index under test, 1..NDIV |
| rd_valid_i | input | 1 | Read word valid |
| rd_data_i | input | 32 | Read word |
| rd_req_o | output | 1 | One-cycle request for a WORDS-word region read |
| rd_slow_o | output | 1 | Current read is the slow reference read |
| timing_o | output | 4*NDIV | Timing register, one 4-bit field per divider |
| status_o | output | 2 | 0 none, 1 ok, 2 skipped, 3 verify failure |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A read request is due in the cycle after a start edge, or in the cycle after the final word of the previous read. The bench responder reacts at the falling edge where it first sees the request and streams words from that edge on. `done_o` and the final `timing_o` and `status_o` are due one cycle after the last accepted word. The bench records the cycle of that last word and checks the completion exactly one cycle later. It checks the following cycle for the pulse falling and the status holding. Candidate codes are checked at every test-read request against the sequence the bench predicts from its own pass/fail plan.

// File: rtl/calib_pkg.sv
package calib_pkg;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_OK   = 2'd1,
        ST_SKIP = 2'd2,
        ST_FAIL = 2'd3
    } cal_status_e;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

endpackage

// File: rtl/calib_crc_step.sv
module calib_crc_step (
    input  logic [31:0] crc_i,
    input  logic [31:0] data_i,
    output logic [31:0] crc_o
);
    import calib_pkg::*;

    logic [32:0][31:0] chain;

    assign chain[0] = crc_i;

    for (genvar b = 0; b < 32; b++) begin : g_bit
        assign chain[b+1] = (chain[b] >> 1) ^ (CRC_POLY & {32{chain[b][0] ^ data_i[b]}});
    end

    assign crc_o = chain[32];

endmodule

// File: rtl/calib_word_class.sv
module calib_word_class #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             varied_o
);
    assign varied_o = (data_i != '0) && (data_i != '1);
endmodule

// File: rtl/spi_rd_calib.sv
module spi_rd_calib #(
    parameter int NDIV       = 5,
    parameter int WORDS      = 4096,
    parameter int REPEATS    = 10,
    parameter int CANDS      = 12,
    parameter int MIN_VARIED = 64,
    parameter int RUN_LEN    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [$clog2(NDIV+1)-1:0]  div_i,
    input  logic                       rd_valid_i,
    input  logic [31:0]                rd_data_i,
    output logic                       rd_req_o,
    output logic                       rd_slow_o,
    output logic [4*NDIV-1:0]          timing_o,
    output logic [1:0]                 status_o,
    output logic                       done_o
);
    import calib_pkg::*;

    localparam int DVW = $clog2(NDIV + 1);
    localparam int FIW = $clog2(NDIV);
    localparam int WCW = $clog2(WORDS);
    localparam int VW  = $clog2(WORDS + 1);
    localparam int RPW = $clog2(REPEATS);
    localparam int RNW = $clog2(RUN_LEN + 1);
    localparam int CW  = $clog2(CANDS);

    typedef struct packed {
        logic                   busy;
        logic                   is_ref;
        logic [DVW-1:0]         div;
        logic [CW-1:0]          cand;
        logic [RPW-1:0]         rep;
        logic [RNW-1:0]         run;
        logic [WCW-1:0]         wcnt;
        logic [31:0]            crc;
        logic [31:0]            ref_crc;
        logic [VW-1:0]          nvar;
        logic [NDIV-1:0][3:0]   fld;
        cal_status_e            status;
        logic                   done;
        logic                   req;
    } state_t;

    state_t q, d;

    logic [31:0]    crc_next;
    logic           word_varied;
    logic [FIW-1:0] idx_q;
    logic [FIW-1:0] idx_start;
    logic           div_ok;
    logic           last_word;
    logic           crc_match;
    logic [VW-1:0]  nvar_final;
    logic [RNW-1:0] run_next;

    function automatic logic [3:0] cand_code(input logic [CW-1:0] c);
        return {~c[0], 3'(c >> 1)};
    endfunction

    calib_crc_step u_crc (
        .crc_i  (q.crc),
        .data_i (rd_data_i),
        .crc_o  (crc_next)
    );

    calib_word_class #(.WIDTH(32)) u_class (
        .data_i   (rd_data_i),
        .varied_o (word_varied)
    );

    assign idx_q      = FIW'(q.div - DVW'(1));
    assign idx_start  = FIW'(div_i - DVW'(1));
    assign div_ok     = (div_i != '0) && (div_i <= DVW'(NDIV));
    assign last_word  = (q.wcnt == WCW'(WORDS - 1));
    assign crc_match  = (crc_next == q.ref_crc);
    assign nvar_final = q.nvar + VW'(word_varied);
    assign run_next   = crc_match ? (q.run + RNW'(1)) : '0;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.req  = 1'b0;
        if (!q.busy) begin
            if (start_i && div_ok) begin
                d.busy           = 1'b1;
                d.is_ref         = 1'b1;
                d.div            = div_i;
                d.fld[idx_start] = 4'h0;
                d.wcnt           = '0;
                d.nvar           = '0;
                d.crc            = CRC_INIT;
                d.req            = 1'b1;
            end
        end else if (rd_valid_i) begin
            d.crc  = crc_next;
            d.wcnt = q.wcnt + WCW'(1);
            if (q.is_ref) begin
                d.nvar = nvar_final;
            end
            if (last_word) begin
                d.wcnt = '0;
                d.crc  = CRC_INIT;
                if (q.is_ref) begin
                    d.ref_crc = crc_next;
                    if (nvar_final < VW'(MIN_VARIED)) begin
                        d.busy   = 1'b0;
                        d.done   = 1'b1;
                        d.status = ST_SKIP;
                    end else begin
                        d.is_ref     = 1'b0;
                        d.cand       = '0;
                        d.rep        = '0;
                        d.run        = '0;
                        d.fld[idx_q] = cand_code('0);
                        d.req        = 1'b1;
                    end
                end else if (crc_match && (q.rep != RPW'(REPEATS - 1))) begin
                    d.rep = q.rep + RPW'(1);
                    d.req = 1'b1;
                end else if (crc_match && (run_next == RNW'(RUN_LEN))) begin
                    d.fld[idx_q] = cand_code(q.cand - CW'(RUN_LEN / 2));
                    d.busy       = 1'b0;
                    d.done       = 1'b1;
                    d.status     = ST_OK;
                end else if (q.cand == CW'(CANDS - 1)) begin
                    d.fld[idx_q] = 4'h0;
                    d.busy       = 1'b0;
                    d.done       = 1'b1;
                    d.status     = ST_FAIL;
                end else begin
                    d.cand       = q.cand + CW'(1);
                    d.rep        = '0;
                    d.run        = run_next;
                    d.fld[idx_q] = cand_code(q.cand + CW'(1));
                    d.req        = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= state_t'('0);
        end else begin
            q <= d;
        end
    end

    assign rd_req_o  = q.req;
    assign rd_slow_o = q.busy & q.is_ref;
    assign timing_o  = q.fld;
    assign status_o  = q.status;
    assign done_o    = q.done;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done held longer than one cycle");

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(status_o))
        else $error("status changed without done");

    assert_idle_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !start_i) |=> $stable(timing_o))
        else $error("timing changed while idle");

    assert_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (q.busy && !done_o))
        else $error("read request outside a calibration");

    assert_cand_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cand < CW'(CANDS)))
        else $error("candidate index out of range");

    assert_slow_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_slow_o |-> (q.fld[idx_q] == 4'h0))
        else $error("field not cleared during reference read");

    assert_bad_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && start_i && !div_ok) |=> !rd_req_o)
        else $error("invalid divider started a calibration");

    for (genvar k = 0; k < NDIV; k++) begin : g_fld_chk
        assert_other_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (q.busy && (q.div != DVW'(k + 1))) |=> $stable(q.fld[k]))
            else $error("foreign divider field changed");
    end

endmodule

// File: tb/spi_rd_calib_tb_top.sv
module spi_rd_calib_tb_top;

    localparam int NDIV  = 5;
    localparam int W     = 32;
    localparam int REP   = 10;
    localparam int NC    = 12;
    localparam int MINV  = 8;
    localparam int DVW   = $clog2(NDIV + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [DVW-1:0]  div_i = '0;
    logic            rd_valid_i = 1'b0;
    logic [31:0]     rd_data_i = '0;
    logic            rd_req_o, rd_slow_o, done_o;
    logic [4*NDIV-1:0] timing_o;
    logic [1:0]      status_o;

    spi_rd_calib #(
        .NDIV(NDIV), .WORDS(W), .REPEATS(REP), .CANDS(NC),
        .MIN_VARIED(MINV), .RUN_LEN(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .rd_req_o(rd_req_o), .rd_slow_o(rd_slow_o), .timing_o(timing_o),
        .status_o(status_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [11:0] cfg_mask;
    int          cfg_fr;
    int          cfg_nvar;
    logic [23:0] cfg_seed;
    int          cur_div;
    int          req_count;
    int          last_word_cyc;
    logic [3:0]  exp_fld [1:NDIV];

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(input int k);
        if (k < cfg_nvar) return {8'h5A, 24'(k * 24'h9E37) ^ cfg_seed};
        return k[0] ? 32'hFFFF_FFFF : 32'h0;
    endfunction

    function automatic logic [3:0] code(input int i);
        return {~i[0], 3'(i / 2)};
    endfunction

    function automatic logic [3:0] field_of(input int dv);
        return timing_o[4*(dv-1) +: 4];
    endfunction

    // Responder: emulates the flash read engine
    initial begin
        int idx = 0;
        bit active = 0;
        bit is_ref = 0;
        int ec = 0;
        int er = 0;
        logic [31:0] w;
        forever begin
            @(negedge clk);
            if (rd_req_o) begin
                req_count++;
                idx = 0;
                active = 1;
                is_ref = rd_slow_o;
                if (is_ref) begin
                    ec = 0; er = 0;
                    chk(field_of(cur_div) == 4'h0, "R2", "field during reference",
                        field_of(cur_div), 0);
                end else begin
                    chk(field_of(cur_div) == code(ec) && !rd_slow_o, "R4",
                        "candidate code", field_of(cur_div), code(ec));
                end
            end
            if (active) begin
                w = ref_word(idx);
                if (!is_ref && !cfg_mask[ec] && er == cfg_fr &&
                    idx == (int'(cfg_seed) + ec) % W)
                    w = w ^ (32'h1 << (er % 32));
                rd_valid_i = 1'b1;
                rd_data_i  = w;
                idx++;
                if (idx == W) begin
                    active = 0;
                    last_word_cyc = cyc;
                    if (!is_ref) begin
                        if (cfg_mask[ec] ? (er == REP - 1) : (er == cfg_fr)) begin
                            ec++; er = 0;
                        end else er++;
                    end
                end
            end else begin
                rd_valid_i = 1'b0;
                rd_data_i  = '0;
            end
        end
    end

    task automatic model(input logic [11:0] m, input int fr, output int sel, output int reqs);
        int run = 0;
        sel = -1;
        reqs = 1;
        for (int i = 0; i < NC; i++) begin
            if (m[i]) begin
                reqs += REP;
                run++;
                if (run == 3) begin sel = i - 1; break; end
            end else begin
                reqs += fr + 1;
                run = 0;
            end
        end
    endtask

    task automatic run_cal(input int dv, input logic [11:0] m, input int fr,
                           input int nv, input logic [23:0] sd, input bit mid_start,
                           input string tag);
        int sel, reqs, exp_status, waited;
        logic [1:0] st;
        logic [4*NDIV-1:0] exp_t;
        cfg_mask = m; cfg_fr = fr; cfg_nvar = nv; cfg_seed = sd; cur_div = dv;
        req_count = 0;
        if (nv < MINV) begin sel = -1; reqs = 1; exp_status = 2; end
        else begin
            model(m, fr, sel, reqs);
            exp_status = (sel < 0) ? 3 : 1;
        end
        @(negedge clk);
        start_i = 1'b1; div_i = DVW'(dv);
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (mid_start && waited == 100) begin
                start_i = 1'b1; div_i = DVW'((dv % NDIV) + 1);
            end else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(done_o, tag, "done seen", done_o, 1);
        chk(cyc == last_word_cyc + 1, "R8", "done latency", cyc - last_word_cyc, 1);
        chk(status_o == 2'(exp_status), exp_status == 1 ? "R6" : (exp_status == 2 ? "R3" : "R7"),
            "status", status_o, exp_status);
        exp_fld[dv] = (sel < 0) ? 4'h0 : code(sel);
        for (int k = 1; k <= NDIV; k++) exp_t[4*(k-1) +: 4] = exp_fld[k];
        chk(timing_o == exp_t, "R9", "timing register", timing_o, exp_t);
        chk(req_count == reqs, mid_start ? "R10" : "R5", "read count", req_count, reqs);
        st = status_o;
        @(negedge clk);
        chk(!done_o && !rd_req_o, "R8", "done pulse ends", done_o, 0);
        repeat (5) @(negedge clk);
        chk(status_o == st && timing_o == exp_t, "R8", "results hold",
            {status_o, timing_o}, {st, exp_t});
    endtask

    initial begin
        int junk;
        junk = $urandom(32'd20240611);
        for (int k = 1; k <= NDIV; k++) exp_fld[k] = 4'h0;
        repeat (3) @(negedge clk);
        chk(timing_o == '0 && status_o == 2'd0 && !done_o && !rd_req_o && !rd_slow_o,
            "R1", "reset state", {timing_o, status_o, done_o, rd_req_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cal(2, 12'hFFF, 0, W, 24'h1111, 0, "R6");          // first three pass -> 1
        run_cal(3, 12'hE00, 4, W, 24'h2222, 0, "R6");          // last three -> 10
        run_cal(1, 12'b1111_1111_1011, 9, 20, 24'h3333, 0, "R6"); // run reset -> 4
        run_cal(4, 12'h000, 0, W, 24'h4444, 0, "R7");
        run_cal(5, 12'b0110_1101_1011, 9, W, 24'h5555, 0, "R7");
        run_cal(1, 12'hFFF, 0, MINV - 1, 24'h6666, 0, "R3");   // too uniform
        run_cal(1, 12'hFFF, 0, MINV, 24'h7777, 0, "R3");       // boundary proceeds
        run_cal(2, 12'h0F0, 3, W, 24'h8888, 1, "R10");         // start while busy

        // invalid dividers
        for (int b = 0; b < 2; b++) begin
            logic [4*NDIV-1:0] t0;
            t0 = timing_o;
            req_count = 0;
            @(negedge clk);
            start_i = 1'b1; div_i = (b == 0) ? DVW'(0) : DVW'(NDIV + 1);
            @(negedge clk);
            start_i = 1'b0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (done_o) req_count += 100;
            end
            chk(req_count == 0 && timing_o == t0, "R10", "bad divider ignored",
                req_count, 0);
        end

        for (int r = 0; r < 6; r++) begin
            logic [11:0] m;
            m = 12'($urandom) | 12'($urandom);
            run_cal($urandom_range(1, NDIV), m, $urandom_range(0, REP - 1),
                    $urandom_range(MINV, W), 24'($urandom), 0, "R6");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule